// File: doc/BRIEF.md
# Serial EEPROM Write Guard and Program Sequencer

This block sits between the instruction decoder of a serial-bus EEPROM and its storage array. It holds the programmable part of the status byte and decides whether each write request from the decoder may go ahead. The decoder sends single-cycle strobes: arm the write latch, disarm it, update the status byte, or commit a buffered page (base address, up to eight bytes, and a byte mask). A commit or status update is accepted only when three conditions hold. The latch must be armed, the hardware guard pin must be high, and, for a page, the target must lie outside the region that the block-protect field locks.

An accepted request starts a fixed-length internal program cycle, and busy is reported for its whole duration. The captured page goes to the array through a write port that pulses only in the final clock of the cycle. The latch disarms itself when any cycle ends, so each write needs a fresh arm.

The sequencer has three named states. ST_IDLE waits for work. ST_PAGE runs a page cycle. ST_SREG runs a status cycle. The transitions are: accept_page (ST_IDLE to ST_PAGE), accept_sreg (ST_IDLE to ST_SREG), page_done (ST_PAGE to ST_IDLE) and sreg_done (ST_SREG to ST_IDLE). Each done transition is taken in the last clock of the cycle.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: After reset, status_out is 0x00, busy is 0 and arr_we is 0.
- R2: Status bit 1 shows the write latch. In ST_IDLE, a set_wel strobe makes it 1 from the next cycle and a clr_wel strobe makes it 0 from the next cycle. When both strobes arrive together, clr_wel wins.
- R3: While the write latch is 0, commit and wr_status strobes start no cycle and change nothing.
- R4: While wp_n is 0, commit and wr_status strobes start no cycle, and the write latch keeps its value.
- R5: The block-protect field is status bits 3:2. Its encoding for a 7-bit address is: 00 locks nothing; 01 locks 0x60 to 0x7F; 10 locks 0x40 to 0x7F; 11 locks every address. A commit to a locked base address is dropped. It starts no cycle and leaves the latch armed.
- R6: An accepted request raises busy and status bit 0 in the cycle after the strobe, and both stay at 1 for exactly PROG_CYCLES cycles.
- R7: arr_we is 1 only in the last busy cycle of a page cycle. In that cycle, arr_addr, arr_data and arr_mask carry the values captured at the commit. A status cycle never raises arr_we.
- R8: A status update loads status_bp_in into bits 3:2 in the last cycle of its program cycle. Until then, bits 3:2 keep their old value.
- R9: The write latch is 0 from the cycle in which busy falls.
- R10: While busy, all four strobes are ignored. The latch, the block-protect field and the cycle length do not change.
- R11: Status bits 7:4 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_n | input | 1 | Hardware write guard; 0 blocks all writes |
| set_wel | input | 1 | Strobe: arm write latch |
| clr_wel | input | 1 | Strobe: disarm write latch |
| wr_status | input | 1 | Strobe: status-byte update |
| status_bp_in | input | 2 | New block-protect value for a status update |
| commit | input | 1 | Strobe: program a page |
| commit_addr | input | ADDR_W | Page base address |
| commit_data | input | PAGE_BYTES*8 | Page bytes, byte 0 in the low bits |
| commit_mask | input | PAGE_BYTES | Byte enables for the page |
| status_out | output | 8 | Status byte: bit 0 busy, bit 1 latch, bits 3:2 block protect |
| busy | output | 1 | Program cycle in progress |
| arr_we | output | 1 | Array write pulse |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | PAGE_BYTES*8 | Array write data |
| arr_mask | output | PAGE_BYTES | Array byte enables |

## Verification
The bench builds the block with ADDR_W=7, PAGE_BYTES=8 and PROG_CYCLES=6. A program cycle therefore lasts only a few clocks, so the bench can count every busy clock and pin down the exact cycle of the array pulse. The 7-bit address gives the real quarter boundaries (0x60 and 0x40), so the bench probes the addresses on either side of each lock boundary. The bench also aims strobes into the middle of a running cycle to show that they are ignored.

// File: rtl/eewp_pkg.sv
package eewp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PAGE = 2'd1,
        ST_SREG = 2'd2
    } eewp_state_e;

    localparam logic [1:0] BP_NONE    = 2'b00;
    localparam logic [1:0] BP_QUARTER = 2'b01;
    localparam logic [1:0] BP_HALF    = 2'b10;
    localparam logic [1:0] BP_ALL     = 2'b11;

endpackage

// File: rtl/eewp_region_chk.sv
module eewp_region_chk
    import eewp_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);

    localparam int TOP = ADDR_W - 1;

    generate
        if (ADDR_W >= 2) begin : g_quarters
            always_comb begin
                unique case (bp)
                    BP_NONE:    locked = 1'b0;
                    BP_QUARTER: locked = addr[TOP] & addr[TOP-1];
                    BP_HALF:    locked = addr[TOP];
                    default:    locked = 1'b1;
                endcase
            end
        end else begin : g_tiny
            always_comb begin
                unique case (bp)
                    BP_NONE:    locked = 1'b0;
                    BP_QUARTER: locked = 1'b0;
                    BP_HALF:    locked = addr[TOP];
                    default:    locked = 1'b1;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/eewp_cycle_timer.sv
module eewp_cycle_timer #(
    parameter int PROG_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);

    localparam int CNT_W = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(PROG_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = run && (cnt == LAST_VAL);

endmodule

// File: rtl/eewp_page_buf.sv
module eewp_page_buf #(
    parameter int ADDR_W     = 7,
    parameter int PAGE_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       in_addr,
    input  logic [PAGE_BYTES*8-1:0] in_data,
    input  logic [PAGE_BYTES-1:0]   in_mask,
    output logic [ADDR_W-1:0]       out_addr,
    output logic [PAGE_BYTES*8-1:0] out_data,
    output logic [PAGE_BYTES-1:0]   out_mask
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_addr <= '0;
            out_mask <= '0;
        end else if (load) begin
            out_addr <= in_addr;
            out_mask <= in_mask;
        end
    end

    for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_data[b*8 +: 8] <= '0;
            end else if (load) begin
                out_data[b*8 +: 8] <= in_data[b*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
    import eewp_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int PAGE_BYTES  = 8,
    parameter int PROG_CYCLES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wp_n,
    input  logic                    set_wel,
    input  logic                    clr_wel,
    input  logic                    wr_status,
    input  logic [1:0]              status_bp_in,
    input  logic                    commit,
    input  logic [ADDR_W-1:0]       commit_addr,
    input  logic [PAGE_BYTES*8-1:0] commit_data,
    input  logic [PAGE_BYTES-1:0]   commit_mask,
    output logic [7:0]              status_out,
    output logic                    busy,
    output logic                    arr_we,
    output logic [ADDR_W-1:0]       arr_addr,
    output logic [PAGE_BYTES*8-1:0] arr_data,
    output logic [PAGE_BYTES-1:0]   arr_mask
);

    eewp_state_e state_q, state_d;
    logic        wel_q;
    logic [1:0]  bp_q;
    logic [1:0]  bp_pend_q;
    logic        locked;
    logic        cyc_last;
    logic        in_cycle;
    logic        write_ok;
    logic        accept_page;
    logic        accept_sreg;

    eewp_region_chk #(.ADDR_W(ADDR_W)) u_region (
        .bp     (bp_q),
        .addr   (commit_addr),
        .locked (locked)
    );

    eewp_cycle_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_cycle),
        .last  (cyc_last)
    );

    eewp_page_buf #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept_page),
        .in_addr  (commit_addr),
        .in_data  (commit_data),
        .in_mask  (commit_mask),
        .out_addr (arr_addr),
        .out_data (arr_data),
        .out_mask (arr_mask)
    );

    assign in_cycle    = (state_q != ST_IDLE);
    assign write_ok    = (state_q == ST_IDLE) && wel_q && wp_n;
    assign accept_page = write_ok && commit && !locked;
    assign accept_sreg = write_ok && !commit && wr_status;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_page) begin
                    state_d = ST_PAGE;
                end else if (accept_sreg) begin
                    state_d = ST_SREG;
                end
            end
            ST_PAGE: if (cyc_last) state_d = ST_IDLE;
            ST_SREG: if (cyc_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // latch, protect field and pending status value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q     <= 1'b0;
            bp_q      <= BP_NONE;
            bp_pend_q <= BP_NONE;
        end else begin
            if (in_cycle && cyc_last) begin
                wel_q <= 1'b0;
            end else if (state_q == ST_IDLE) begin
                if (clr_wel) begin
                    wel_q <= 1'b0;
                end else if (set_wel) begin
                    wel_q <= 1'b1;
                end
            end
            if (accept_sreg) begin
                bp_pend_q <= status_bp_in;
            end
            if (state_q == ST_SREG && cyc_last) begin
                bp_q <= bp_pend_q;
            end
        end
    end

    // outputs
    always_comb begin
        busy   = 1'b0;
        arr_we = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PAGE: begin
                busy   = 1'b1;
                arr_we = cyc_last;
            end
            ST_SREG: busy = 1'b1;
            default: ;
        endcase
        status_out = {4'b0000, bp_q, wel_q, busy};
    end

endmodule

// File: rtl/eewp_checker.sv
module eewp_checker #(
    parameter int PROG_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n,
    input logic [7:0] status_out,
    input logic       busy,
    input logic       arr_we
);

    int unsigned run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= 0;
        end else if (!busy) begin
            run_cnt <= 0;
        end else begin
            run_cnt <= run_cnt + 1;
        end
    end

    assert_cycle_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < PROG_CYCLES));

    assert_cycle_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == PROG_CYCLES));

    assert_we_in_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    assert_we_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> !busy);

    assert_guard_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wp_n) |=> !busy);

    assert_no_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !status_out[1]) |=> !busy);

    assert_latch_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !status_out[1]);

    assert_bp_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(status_out[3:2])));

    assert_latch_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && status_out[1]) |=> (!busy || status_out[1]));

    assert_high_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (status_out[7:4] == 4'h0));

endmodule

bind eeprom_wp_ctrl eewp_checker #(.PROG_CYCLES(PROG_CYCLES)) u_eewp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_n       (wp_n),
    .status_out (status_out),
    .busy       (busy),
    .arr_we     (arr_we)
);

// File: tb/eeprom_wp_ctrl_bench.sv
`timescale 1ns/1ps
module eeprom_wp_ctrl_bench;

    localparam int AW  = 7;
    localparam int PB  = 8;
    localparam int PC  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_n = 1'b1;
    logic          set_wel = 1'b0;
    logic          clr_wel = 1'b0;
    logic          wr_status = 1'b0;
    logic [1:0]    status_bp_in = 2'b00;
    logic          commit = 1'b0;
    logic [AW-1:0] commit_addr = '0;
    logic [PB*8-1:0] commit_data = '0;
    logic [PB-1:0] commit_mask = '0;
    logic [7:0]    status_out;
    logic          busy;
    logic          arr_we;
    logic [AW-1:0] arr_addr;
    logic [PB*8-1:0] arr_data;
    logic [PB-1:0] arr_mask;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    eeprom_wp_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .PROG_CYCLES(PC)) u_eeprom_wp_ctrl (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .set_wel(set_wel), .clr_wel(clr_wel),
        .wr_status(wr_status), .status_bp_in(status_bp_in), .commit(commit),
        .commit_addr(commit_addr), .commit_data(commit_data), .commit_mask(commit_mask),
        .status_out(status_out), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_data(arr_data), .arr_mask(arr_mask)
    );

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // all strobes: raised at a falling edge, dropped at the next one
    task automatic pulse_set();   set_wel = 1'b1; @(negedge clk); set_wel = 1'b0; endtask
    task automatic pulse_clr();   clr_wel = 1'b1; @(negedge clk); clr_wel = 1'b0; endtask
    task automatic pulse_sreg(input logic [1:0] v);
        status_bp_in = v; wr_status = 1'b1; @(negedge clk); wr_status = 1'b0;
    endtask
    task automatic pulse_commit(input logic [AW-1:0] a, input logic [PB*8-1:0] d,
                                input logic [PB-1:0] m);
        commit_addr = a; commit_data = d; commit_mask = m;
        commit = 1'b1; @(negedge clk); commit = 1'b0;
    endtask

    // called one cycle after an accepted strobe; walks the whole cycle
    task automatic walk_cycle(input string req, input bit page, input logic [AW-1:0] a,
                              input logic [PB*8-1:0] d, input logic [PB-1:0] m);
        for (int k = 1; k <= PC; k++) begin
            check(req, "busy in cycle", busy, 1'b1);
            check(req, "status bit0 in cycle", status_out[0], 1'b1);
            check(req, "arr_we timing", arr_we, (page && k == PC));
            if (page && k == PC) begin
                check(req, "arr_addr", arr_addr, a);
                check(req, "arr_data", arr_data, d);
                check(req, "arr_mask", arr_mask, m);
            end
            @(negedge clk);
        end
        check(req, "busy after cycle", busy, 1'b0);
        check("R9", "latch after cycle", status_out[1], 1'b0);
    endtask

    task automatic load_bp(input logic [1:0] v);
        pulse_set();
        pulse_sreg(v);
        walk_cycle("R8", 1'b0, '0, '0, '0);
        check("R8", "bp loaded", status_out[3:2], v);
    endtask

    task automatic t_reset();
        check("R1", "status after reset", status_out, 8'h00);
        check("R1", "busy after reset", busy, 1'b0);
        check("R1", "arr_we after reset", arr_we, 1'b0);
    endtask

    task automatic t_latch();
        pulse_set();
        check("R2", "set latch", status_out, 8'h02);
        pulse_clr();
        check("R2", "clear latch", status_out, 8'h00);
        set_wel = 1'b1; clr_wel = 1'b1; @(negedge clk); set_wel = 1'b0; clr_wel = 1'b0;
        check("R2", "clear wins", status_out, 8'h00);
    endtask

    task automatic t_no_latch();
        pulse_commit(7'h10, 64'h1122334455667788, 8'hFF);
        check("R3", "commit w/o latch busy", busy, 1'b0);
        pulse_sreg(2'b11);
        check("R3", "sreg w/o latch busy", busy, 1'b0);
        @(negedge clk);
        check("R3", "sreg w/o latch status", status_out, 8'h00);
    endtask

    task automatic t_guard();
        pulse_set();
        wp_n = 1'b0;
        pulse_commit(7'h08, 64'hA5, 8'h01);
        check("R4", "commit guarded busy", busy, 1'b0);
        pulse_sreg(2'b10);
        check("R4", "sreg guarded busy", busy, 1'b0);
        @(negedge clk);
        check("R4", "latch kept under guard", status_out, 8'h02);
        wp_n = 1'b1;
        pulse_clr();
    endtask

    task automatic t_page();
        pulse_set();
        pulse_commit(7'h18, 64'hDEADBEEF_01234567, 8'hA5);
        check("R6", "status in cycle", status_out, 8'h03);
        walk_cycle("R7", 1'b1, 7'h18, 64'hDEADBEEF_01234567, 8'hA5);
        check("R9", "status after page", status_out, 8'h00);
    endtask

    task automatic t_sreg();
        pulse_set();
        pulse_sreg(2'b01);
        check("R8", "bp held during cycle", status_out, 8'h03);
        walk_cycle("R8", 1'b0, '0, '0, '0);
        check("R8", "bp after cycle", status_out, 8'h04);
        check("R11", "upper bits zero", status_out[7:4], 4'h0);
    endtask

    task automatic t_region();
        // bp=01 from t_sreg
        pulse_set();
        pulse_commit(7'h60, 64'h1, 8'h1);
        check("R5", "quarter lock 0x60", busy, 1'b0);
        check("R5", "latch kept after drop", status_out, 8'h06);
        pulse_commit(7'h58, 64'h2, 8'h3);
        walk_cycle("R5", 1'b1, 7'h58, 64'h2, 8'h3);
        load_bp(2'b10);
        pulse_set();
        pulse_commit(7'h40, 64'h3, 8'h1);
        check("R5", "half lock 0x40", busy, 1'b0);
        pulse_commit(7'h38, 64'h4, 8'h80);
        walk_cycle("R5", 1'b1, 7'h38, 64'h4, 8'h80);
        load_bp(2'b11);
        pulse_set();
        pulse_commit(7'h00, 64'h5, 8'h1);
        check("R5", "full lock 0x00", busy, 1'b0);
        pulse_clr();
        load_bp(2'b00);
        pulse_set();
        pulse_commit(7'h78, 64'h6, 8'hF0);
        walk_cycle("R5", 1'b1, 7'h78, 64'h6, 8'hF0);
    endtask

    task automatic t_busy_ignore();
        pulse_set();
        pulse_commit(7'h20, 64'hCAFE, 8'h0F);
        // k=1 sampled now; spend cycles 1..3 on ignored strobes
        check("R10", "busy start", busy, 1'b1);
        pulse_clr();
        check("R10", "latch held while busy", status_out[1], 1'b1);
        pulse_sreg(2'b11);
        pulse_commit(7'h30, 64'hBEEF, 8'hFF);
        for (int k = 4; k <= PC; k++) begin
            check("R10", "busy continues", busy, 1'b1);
            check("R10", "arr_we timing", arr_we, (k == PC));
            if (k == PC) check("R10", "addr not replaced", arr_addr, 7'h20);
            @(negedge clk);
        end
        check("R10", "cycle not extended", busy, 1'b0);
        @(negedge clk);
        check("R10", "no queued cycle", busy, 1'b0);
        check("R10", "bp unchanged", status_out, 8'h00);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_no_latch();
        t_guard();
        t_page();
        t_sreg();
        t_region();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule